// File: doc/BRIEF.md
# SPI FIFO Event and Interrupt Unit

This block sits beside the byte FIFOs of an SPI master and turns their state into a 32-bit event word, a matching interrupt mask and one interrupt line. Its inputs are the receive FIFO byte count, the transmit FIFO free count and a one-cycle transfer-done pulse. A mode register holds a global enable, a loopback control and two watermark thresholds, one for transmit and one for receive. The FIFO storage and the serial shifter are outside this block.

The event word has two kinds of content. Some of it is live: both occupancy counts and the two level flags derived from them. The rest is sticky: transmit empty, done, receive full and the two watermark flags. Software reads the word over a small register bus. It clears sticky flags by writing ones to their bit positions, usually by writing back the value it has just read. The interrupt is asserted while any event bit selected by the mask is set and the unit is enabled.

Top module: `spi_evt_irq_unit`

## Requirements
- R1: After reset the mode, mask and sticky event state are all zero, so with zero counts every register reads 0 and `irq` is low.
- R2: The mode register is at address 0. Enable is bit 31, loopback is bit 30, the 6-bit transmit threshold is bits 13:8 and the 5-bit receive threshold is bits 4:0. All other bits read 0, and `loop_en` follows bit 30.
- R3: The event word is at address 1. Bits 29:24 carry the live `rx_count` and bits 21:16 carry the live `tx_free`.
- R4: Bit 9 is 1 exactly when `rx_count` is nonzero, and bit 8 is 1 exactly when `tx_free` is nonzero. Writing these bits has no effect.
- R5: Sticky bit 13 sets on a clock edge where `rx_count` is strictly greater than the receive threshold. It does not set when the count equals the threshold.
- R6: Sticky bit 11 sets on a clock edge where `tx_free` is greater than or equal to the transmit threshold.
- R7: Sticky bit 15 sets when `tx_free` equals TX_DEPTH. Sticky bit 12 sets when `rx_count` equals RX_DEPTH.
- R8: Sticky bit 14 sets on a clock edge where `xfer_done` is high.
- R9: A write to address 1 clears each sticky flag whose bit is 1 in the written data. Sticky flags written with 0 keep their value.
- R10: When a sticky flag's set condition and its clear arrive on the same edge, the flag ends up set.
- R11: The mask register is at address 2 and uses the event-word bit layout. Only bits 15:11, 9 and 8 are stored, and the others read 0. `irq` is high while the unit is enabled and (event word AND mask) is nonzero.
- R12: While enable is 0, the sticky flags are forced to 0 one edge later and stay there, and `irq` is low. The live fields keep reporting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for an access |
| bus_addr | input | 2 | Register select: 0 mode, 1 event, 2 mask, 3 reads zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_count | input | 6 | Bytes held in the receive FIFO |
| tx_free | input | 6 | Free byte slots in the transmit FIFO |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| loop_en | output | 1 | Loopback control for the shifter |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things. A flag whose set condition holds is set on the next edge, whatever the clear does. A clear with no competing set empties the flag. Sticky state holds when nothing acts on it. Disabling empties all sticky state, and `irq` never rises while disabled. They also tie the live level bit and the loopback pin to the read data. Only the bench scenarios show the exact threshold boundaries (equal versus above), the bit positions of each flag and count field, the mask storage width, and that a flag does not return after the unit is re-enabled.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 6;
  localparam int RXTHR_W = 5;
  localparam int TXTHR_W = 6;
  localparam int NSTICKY = 5;

  // Event word bit positions
  localparam int EV_TXE = 15;
  localparam int EV_DON = 14;
  localparam int EV_RXT = 13;
  localparam int EV_RXF = 12;
  localparam int EV_TXT = 11;
  localparam int EV_RNE = 9;
  localparam int EV_TNF = 8;
  localparam int RXCNT_LSB = 24;
  localparam int TXCNT_LSB = 16;

  // Mode register positions
  localparam int MD_EN   = 31;
  localparam int MD_LOOP = 30;
  localparam int MD_TXTHR_LSB = 8;
  localparam int MD_RXTHR_LSB = 0;

  localparam logic [DATA_W-1:0] MODE_IMPL = 32'hC000_3F1F;
  localparam logic [DATA_W-1:0] FLAG_IMPL = 32'h0000_FB00;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_EVT  = 2'd1,
    A_MASK = 2'd2,
    A_RSVD = 2'd3
  } reg_addr_e;

  // Sticky index order: 0 TXE, 1 DON, 2 RXT, 3 RXF, 4 TXT
  function automatic int sticky_pos(input int idx);
    case (idx)
      0: return EV_TXE;
      1: return EV_DON;
      2: return EV_RXT;
      3: return EV_RXF;
      default: return EV_TXT;
    endcase
  endfunction

  function automatic logic rx_above(input logic [CNT_W-1:0] cnt,
                                    input logic [RXTHR_W-1:0] thr);
    return cnt > CNT_W'(thr);
  endfunction

  function automatic logic tx_reached(input logic [CNT_W-1:0] cnt,
                                      input logic [TXTHR_W-1:0] thr);
    return cnt >= CNT_W'(thr);
  endfunction
endpackage

// File: rtl/spi_evt_ctrl_regs.sv
module spi_evt_ctrl_regs
  import spi_evt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_mode,
  input  logic                wr_mask,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   mode_q,
  output logic [DATA_W-1:0]   mask_q,
  output logic                en,
  output logic                loop,
  output logic [TXTHR_W-1:0]  tx_thr,
  output logic [RXTHR_W-1:0]  rx_thr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata & MODE_IMPL;
      if (wr_mask) mask_q <= wdata & FLAG_IMPL;
    end
  end

  assign en     = mode_q[MD_EN];
  assign loop   = mode_q[MD_LOOP];
  assign tx_thr = mode_q[MD_TXTHR_LSB +: TXTHR_W];
  assign rx_thr = mode_q[MD_RXTHR_LSB +: RXTHR_W];
endmodule

// File: rtl/spi_evt_sticky.sv
module spi_evt_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] sticky_q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)       sticky_q[i] <= 1'b0;
      else if (!en)     sticky_q[i] <= 1'b0;                 // R12
      else if (set_vec[i]) sticky_q[i] <= 1'b1;              // R10 set wins
      else if (clr_vec[i]) sticky_q[i] <= 1'b0;              // R9
    end
  end
endmodule

// File: rtl/spi_evt_word.sv
module spi_evt_word
  import spi_evt_pkg::*;
#(
  parameter int N = NSTICKY
) (
  input  logic [N-1:0]      sticky_q,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_free,
  output logic [DATA_W-1:0] evt_word
);
  logic [DATA_W-1:0] sticky_part;

  always_comb begin
    sticky_part = '0;
    for (int i = 0; i < N; i++) sticky_part[sticky_pos(i)] = sticky_q[i];
  end

  always_comb begin
    evt_word = sticky_part;
    evt_word[RXCNT_LSB +: CNT_W] = rx_count;   // R3
    evt_word[TXCNT_LSB +: CNT_W] = tx_free;
    evt_word[EV_RNE] = |rx_count;              // R4
    evt_word[EV_TNF] = |tx_free;
  end
endmodule

// File: rtl/spi_evt_irq_unit.sv
module spi_evt_irq_unit
  import spi_evt_pkg::*;
#(
  parameter int RX_DEPTH = 32,
  parameter int TX_DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [CNT_W-1:0]    rx_count,
  input  logic [CNT_W-1:0]    tx_free,
  input  logic                xfer_done,
  output logic                loop_en,
  output logic                irq
);
  localparam logic [CNT_W-1:0] RX_FULL_CNT  = CNT_W'(RX_DEPTH);
  localparam logic [CNT_W-1:0] TX_EMPTY_CNT = CNT_W'(TX_DEPTH);

  reg_addr_e addr;
  logic wr_mode, wr_mask, wr_evt;
  logic [DATA_W-1:0] mode_q, mask_q, evt_word;
  logic en;
  logic [TXTHR_W-1:0] tx_thr;
  logic [RXTHR_W-1:0] rx_thr;
  logic [NSTICKY-1:0] set_vec, clr_vec, sticky_q;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_mode = bus_sel && bus_wr && (addr == A_MODE);
  assign wr_evt  = bus_sel && bus_wr && (addr == A_EVT);
  assign wr_mask = bus_sel && bus_wr && (addr == A_MASK);

  spi_evt_ctrl_regs u_regs (
    .clk, .rst_n, .wr_mode, .wr_mask, .wdata(bus_wdata),
    .mode_q, .mask_q, .en, .loop(loop_en), .tx_thr, .rx_thr
  );

  // Set conditions, index order from sticky_pos
  assign set_vec[0] = (tx_free == TX_EMPTY_CNT);      // R7
  assign set_vec[1] = xfer_done;                      // R8
  assign set_vec[2] = rx_above(rx_count, rx_thr);     // R5
  assign set_vec[3] = (rx_count == RX_FULL_CNT);      // R7
  assign set_vec[4] = tx_reached(tx_free, tx_thr);    // R6

  for (genvar i = 0; i < NSTICKY; i++) begin : g_clr
    assign clr_vec[i] = wr_evt && bus_wdata[sticky_pos(i)];
  end

  spi_evt_sticky #(.N(NSTICKY)) u_sticky (
    .clk, .rst_n, .en, .set_vec, .clr_vec, .sticky_q
  );

  spi_evt_word #(.N(NSTICKY)) u_word (
    .sticky_q, .rx_count, .tx_free, .evt_word
  );

  assign irq = en && (|(evt_word & mask_q));          // R11

  always_comb begin
    case (addr)
      A_MODE:  bus_rdata = mode_q;
      A_EVT:   bus_rdata = evt_word;
      A_MASK:  bus_rdata = mask_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk
  import spi_evt_pkg::*;
#(
  parameter int N = NSTICKY
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [N-1:0]       set_vec,
  input logic [N-1:0]       clr_vec,
  input logic [N-1:0]       sticky_q,
  input logic               irq,
  input logic               loop_en,
  input logic [1:0]         bus_addr,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [CNT_W-1:0]   rx_count
);
  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ((~sticky_q & $past(set_vec)) == '0));

  // R9
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ((clr_vec & ~set_vec) != '0)) |=> ((sticky_q & $past(clr_vec & ~set_vec)) == '0));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (set_vec == '0) && (clr_vec == '0)) |=> $stable(sticky_q));

  // R12
  disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sticky_q == '0));

  // R12
  no_irq_rise_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> en);

  // R4
  rne_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> (bus_rdata[EV_RNE] == (rx_count != '0)));

  // R2
  loop_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[MD_LOOP] == loop_en));
endmodule

bind spi_evt_irq_unit spi_evt_irq_chk #(.N(spi_evt_pkg::NSTICKY)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .set_vec(set_vec), .clr_vec(clr_vec),
  .sticky_q(sticky_q), .irq(irq), .loop_en(loop_en), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .rx_count(rx_count)
);

// File: tb/spi_evt_irq_unit_tb.sv
module spi_evt_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0] rx_count = '0, tx_free = '0;
  logic xfer_done = 1'b0;
  logic loop_en, irq;

  always #2 clk = ~clk;  // 250 MHz

  spi_evt_irq_unit u_dut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .rx_count, .tx_free, .xfer_done, .loop_en, .irq
  );

  typedef struct {
    int    kind;   // 0 read data, 1 irq, 2 loop_en
    logic [31:0] exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // Monitor: pops expected items and compares against the design
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (exp_q.size() > 0);
      it = exp_q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {31'b0, irq};
        default: act = {31'b0, loop_en};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    push(0, exp, tag);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk);
    #1;
    push(1, {31'b0, exp}, tag);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, 32'h0, "R1 mode");
    rd(2'd2, 32'h0, "R1 mask");
    rd(2'd1, 32'h0, "R1 event");
    chk_irq(1'b0, "R1 irq");

    // R2 mode layout, junk bits dropped
    wr(2'd0, 32'hC0F0_E8FF);
    rd(2'd0, 32'hC000_281F, "R2 mode readback");
    push(2, 32'h1, "R2 loop_en");
    rd(2'd3, 32'h0, "R2 unused address");

    // R3 / R4 live fields
    @(negedge clk); rx_count = 5; tx_free = 10;
    rd(2'd1, 32'h050A_0300, "R3 counts");
    wr(2'd1, 32'h0000_0300);
    rd(2'd1, 32'h050A_0300, "R4 write ignored");

    // R5 boundary then strict above
    @(negedge clk); rx_count = 4;
    wr(2'd0, 32'hC000_2804);
    cyc(1);
    rd(2'd1, 32'h040A_0300, "R5 equal no set");
    @(negedge clk); rx_count = 5;
    cyc(1); rx_count = 0;
    rd(2'd1, 32'h000A_2100, "R5 above sets sticky");

    // R9 clear
    wr(2'd1, 32'h0000_2000);
    rd(2'd1, 32'h000A_0100, "R9 clear RXT");

    // R6 transmit watermark
    wr(2'd0, 32'hC000_0C1F);
    @(negedge clk); tx_free = 11;
    cyc(1);
    rd(2'd1, 32'h000B_0100, "R6 below no set");
    @(negedge clk); tx_free = 12;
    cyc(1); tx_free = 10;
    rd(2'd1, 32'h000A_0900, "R6 reach sets");

    // R8 done pulse
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    rd(2'd1, 32'h000A_4900, "R8 done set");
    wr(2'd1, 32'h0000_0800);
    rd(2'd1, 32'h000A_4100, "R9 zero bits keep");

    // R7 empty and full
    @(negedge clk); tx_free = 32;
    cyc(1); tx_free = 10;
    rd(2'd1, 32'h000A_C900, "R7 tx empty");
    @(negedge clk); rx_count = 32;
    cyc(1); rx_count = 0;
    rd(2'd1, 32'h000A_F900, "R7 rx full");

    // R11 mask and irq
    chk_irq(1'b0, "R11 mask zero");
    wr(2'd2, 32'h0000_0200);
    chk_irq(1'b0, "R11 RNE masked, rx empty");
    @(negedge clk); rx_count = 1;
    chk_irq(1'b1, "R11 RNE live irq");
    wr(2'd2, 32'h0000_4000);
    chk_irq(1'b1, "R11 DON irq");
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, 32'h0000_FB00, "R11 mask storage");

    // R9 clear all
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h010A_0300, "R9 clear all");
    chk_irq(1'b1, "R11 live bit keeps irq");

    // R10 set and clear same edge
    @(negedge clk);
    xfer_done = 1; bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 32'h0000_4000;
    @(negedge clk);
    xfer_done = 0; bus_sel = 0; bus_wr = 0;
    rd(2'd1, 32'h010A_4300, "R10 set wins");

    // R12 disable
    wr(2'd0, 32'h0000_0C1F);
    push(2, 32'h0, "R2 loop_en off");
    chk_irq(1'b0, "R12 irq off");
    rd(2'd1, 32'h010A_0300, "R12 sticky emptied");
    @(negedge clk); xfer_done = 1;
    @(negedge clk); xfer_done = 0;
    rd(2'd1, 32'h010A_0300, "R12 done ignored");
    wr(2'd0, 32'hC000_0C1F);
    cyc(1);
    rd(2'd1, 32'h010A_0300, "R12 no return on enable");

    wait (exp_q.size() == 0);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule